// File: doc/BRIEF.md
# Identification ROM Header Integrity Checker

This block validates the contents of a 512-word, 32-bit identification ROM after reset or on request. It drives the ROM's synchronous read port itself, walking the fixed-layout common header and the build-information area in address order. As each word comes back it sums the payload bytes of each area and compares the 8-bit total against the checksum byte stored in that area's closing slot. The checksum is chosen so that the byte sum plus the checksum is zero modulo 256.

While the header streams past, the block also checks the header format version and latches the five section pointers the header carries. It reports whether any pointer lies outside the ROM. At the end of the walk it gives a single-cycle done strobe. The pass flags and decoded pointers then stay steady until the next scan starts, so surrounding logic can sample them at any time.

Word layout, all byte sums taken over the four bytes of a word regardless of their order: header words 0..13 form the header payload, word 14 is a zero pad and word 15 carries the checksum. Words 16..31 form the build-information payload, word 32 is a zero pad and word 33 carries the checksum.

Top module: `idrom_check`

## Requirements
- R1: While rst_n is low, done, header_ok, info_ok, version_ok and range_error are 0. On the first clock edge after rst_n rises, a scan starts without any start pulse.
- R2: A scan presents rom_addr 0, 1, 2, ... 33, one new address per clock, starting in the cycle after start is sampled. It uses each word's data one clock after its address is presented.
- R3: done is high for exactly one cycle, in the 36th cycle after the edge that samples start. A start pulse during a scan is ignored: it neither restarts the address walk nor moves done.
- R4: header_ok is 1 only when all of these hold: (byte sum of words 0..13 + word 15 bits 31:24) mod 256 = 0, word 14 is 0, and word 15 bits 23:0 are 0.
- R5: info_ok is 1 only when all of these hold: (byte sum of words 16..31 + word 33 bits 31:24) mod 256 = 0, word 32 is 0, and word 33 bits 23:0 are 0. A one-byte change anywhere in a payload clears the flag of that area only.
- R6: version_ok is 1 exactly when word 0 equals 1.
- R7: off_info, off_proj, off_board, off_custom and off_second hold bits 8:0 of words 1, 2, 3, 4 and 5 respectively.
- R8: range_error is 1 exactly when any of words 1..5 is 512 or larger. It does not affect header_ok.
- R9: On the edge that samples a start, all pass flags and range_error drop to 0. From done onward they stay constant until the next start, even if the ROM contents change.
- R10: A payload whose byte sum is 0 mod 256 passes with a stored checksum byte of 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new scan (ignored while scanning) |
| rom_addr | output | 9 | Word address to the ROM read port |
| rom_data | input | 32 | ROM read data, valid one clock after its address |
| done | output | 1 | One-cycle strobe at the end of a scan |
| header_ok | output | 1 | Common header checksum and pads correct |
| info_ok | output | 1 | Build-information checksum and pads correct |
| version_ok | output | 1 | Header format version equals 1 |
| range_error | output | 1 | A section pointer is outside the ROM |
| off_info | output | 9 | Build-information area pointer |
| off_proj | output | 9 | Project-name pointer |
| off_board | output | 9 | Board-name pointer |
| off_custom | output | 9 | Custom-string pointer |
| off_second | output | 9 | Second-ROM pointer (0 when unused) |

## Verification
The checker is tried on a correctly sealed image and then on copies with one byte flipped in the header payload, in the build-information payload, in a checksum slot and in a pad word. Each corruption shows that a failure is pinned to the area it occurred in. Images with a wrong version word, a pointer beyond the ROM and a payload summing to zero separate the version, range and zero-checksum paths from the plain checksum path. The address sequence, done timing, a start pulse in mid-scan and a ROM change after done show that data is matched to the right address and that results are held.

// File: rtl/idrom_pkg.sv
package idrom_pkg;

  // Wrapping 8-bit sum of the four bytes of a 32-bit word
  function automatic logic [7:0] word_byte_sum(input logic [31:0] w);
    logic [7:0] acc;
    acc = 8'd0;
    for (int b = 0; b < 4; b++) begin
      acc = acc + w[8*b +: 8];
    end
    return acc;
  endfunction

  // An area passes when its running sum and its stored byte cancel mod 256
  function automatic logic sum_cancels(input logic [7:0] run_sum, input logic [7:0] stored);
    logic [7:0] total;
    total = run_sum + stored;
    return total == 8'd0;
  endfunction

  localparam int NUM_PTRS = 5;

endpackage

// File: rtl/idrom_seq.sv
module idrom_seq #(
  parameter int AW   = 9,
  parameter int LAST = 33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [AW-1:0] addr,
  output logic          issue,
  output logic          accepted
);
  localparam logic [AW-1:0] LAST_A = AW'(LAST);

  logic          boot_pend;
  logic          busy;
  logic [AW-1:0] addr_q;
  logic          at_end;

  assign accepted = (start || boot_pend) && !busy;
  assign at_end   = busy && (addr_q == LAST_A);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_pend <= 1'b1;
      busy      <= 1'b0;
      addr_q    <= '0;
    end else begin
      boot_pend <= 1'b0;
      if (accepted) begin
        busy   <= 1'b1;
        addr_q <= '0;
      end else if (at_end) begin
        busy   <= 1'b0;
      end else if (busy) begin
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  assign addr  = addr_q;
  assign issue = busy;

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !at_end) |=> (addr_q == $past(addr_q) + 1'b1));

  // R2
  addr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (addr_q <= LAST_A));

  // R3
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !at_end) |=> (addr_q != '0));

endmodule

// File: rtl/idrom_pipe.sv
module idrom_pipe #(
  parameter int AW  = 9,
  parameter int LAT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_in,
  input  logic [AW-1:0] addr_in,
  output logic          vld_out,
  output logic [AW-1:0] addr_out
);
  logic [LAT-1:0] vld_sr;
  logic [AW-1:0]  addr_sr [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_sr <= '0;
    end else begin
      vld_sr[0] <= vld_in;
      for (int s = 1; s < LAT; s++) begin
        vld_sr[s] <= vld_sr[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    addr_sr[0] <= addr_in;
    for (int s = 1; s < LAT; s++) begin
      addr_sr[s] <= addr_sr[s-1];
    end
  end

  assign vld_out  = vld_sr[LAT-1];
  assign addr_out = addr_sr[LAT-1];

endmodule

// File: rtl/idrom_area.sv
module idrom_area
  import idrom_pkg::*;
#(
  parameter int AW     = 9,
  parameter int PAY_LO = 0,
  parameter int PAY_HI = 13,
  parameter int PAD    = 14,
  parameter int SLOT   = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          vld,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   data,
  output logic          ok
);
  localparam logic [AW-1:0] LO_A   = AW'(PAY_LO);
  localparam logic [AW-1:0] HI_A   = AW'(PAY_HI);
  localparam logic [AW-1:0] PAD_A  = AW'(PAD);
  localparam logic [AW-1:0] SLOT_A = AW'(SLOT);

  logic [7:0] run_sum;
  logic       pad_clean;
  logic       ok_q;
  logic       in_payload;
  logic       at_pad;
  logic       at_slot;
  logic       verdict;

  assign in_payload = vld && (addr >= LO_A) && (addr <= HI_A);
  assign at_pad     = vld && (addr == PAD_A);
  assign at_slot    = vld && (addr == SLOT_A);
  assign verdict    = sum_cancels(run_sum, data[31:24]) && pad_clean
                      && (data[23:0] == 24'd0);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      run_sum   <= 8'd0;
      pad_clean <= 1'b1;
      ok_q      <= 1'b0;
    end else begin
      if (in_payload) run_sum   <= run_sum + word_byte_sum(data);
      if (at_pad)     pad_clean <= (data == 32'd0);
      if (at_slot)    ok_q      <= verdict;
    end
  end

  assign ok = ok_q;

  // R4 R5
  ok_rise_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> $past(at_slot));

  // R4 R5
  ok_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !ok_q);

endmodule

// File: rtl/idrom_check.sv
module idrom_check
  import idrom_pkg::*;
#(
  parameter int AW        = 9,
  parameter int RD_LAT    = 1,
  parameter int HDR_WORDS = 16,
  parameter int INFO_BASE = 16,
  parameter int INFO_PAY  = 16,
  parameter int FMT_VER   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [AW-1:0] rom_addr,
  input  logic [31:0]   rom_data,
  output logic          done,
  output logic          header_ok,
  output logic          info_ok,
  output logic          version_ok,
  output logic          range_error,
  output logic [AW-1:0] off_info,
  output logic [AW-1:0] off_proj,
  output logic [AW-1:0] off_board,
  output logic [AW-1:0] off_custom,
  output logic [AW-1:0] off_second
);
  localparam int ROM_WORDS = 1 << AW;
  localparam int INFO_HI   = INFO_BASE + INFO_PAY - 1;
  localparam int INFO_PAD  = INFO_BASE + INFO_PAY;
  localparam int INFO_SLOT = INFO_PAD + 1;
  localparam int LAST      = INFO_SLOT;
  localparam logic [AW-1:0] LAST_A = AW'(LAST);
  localparam logic [AW-1:0] VER_A  = '0;

  // Internal events, named for the assertions
  logic          issue;
  logic          accepted;
  logic          p_vld;
  logic [AW-1:0] p_addr;
  logic          scan_end;
  logic [1:0]    area_ok;

  logic          done_q;
  logic          finished;
  logic          ver_q;
  logic          rng_q;
  logic [AW-1:0] ptr_q [NUM_PTRS];

  idrom_seq #(.AW(AW), .LAST(LAST)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .addr     (rom_addr),
    .issue    (issue),
    .accepted (accepted)
  );

  idrom_pipe #(.AW(AW), .LAT(RD_LAT)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .vld_in   (issue),
    .addr_in  (rom_addr),
    .vld_out  (p_vld),
    .addr_out (p_addr)
  );

  for (genvar g = 0; g < 2; g++) begin : g_area
    idrom_area #(
      .AW     (AW),
      .PAY_LO ((g == 0) ? 0             : INFO_BASE),
      .PAY_HI ((g == 0) ? HDR_WORDS - 3 : INFO_HI),
      .PAD    ((g == 0) ? HDR_WORDS - 2 : INFO_PAD),
      .SLOT   ((g == 0) ? HDR_WORDS - 1 : INFO_SLOT)
    ) u_area (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accepted),
      .vld   (p_vld),
      .addr  (p_addr),
      .data  (rom_data),
      .ok    (area_ok[g])
    );
  end

  assign scan_end = p_vld && (p_addr == LAST_A);

  // Version word and pointer capture
  always_ff @(posedge clk) begin
    if (!rst_n || accepted) begin
      ver_q <= 1'b0;
      rng_q <= 1'b0;
      for (int k = 0; k < NUM_PTRS; k++) ptr_q[k] <= '0;
    end else if (p_vld) begin
      if (p_addr == VER_A) ver_q <= (rom_data == 32'(FMT_VER));
      for (int k = 0; k < NUM_PTRS; k++) begin
        if (p_addr == AW'(k + 1)) begin
          ptr_q[k] <= rom_data[AW-1:0];
          if (rom_data >= 32'(ROM_WORDS)) rng_q <= 1'b1;
        end
      end
    end
  end

  // End-of-scan strobe and result hold
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      finished <= 1'b0;
    end else begin
      done_q <= scan_end;
      if (accepted)      finished <= 1'b0;
      else if (scan_end) finished <= 1'b1;
    end
  end

  assign done        = done_q;
  assign header_ok   = finished && area_ok[0];
  assign info_ok     = finished && area_ok[1];
  assign version_ok  = finished && ver_q;
  assign range_error = finished && rng_q;
  assign off_info    = ptr_q[0];
  assign off_proj    = ptr_q[1];
  assign off_board   = ptr_q[2];
  assign off_custom  = ptr_q[3];
  assign off_second  = ptr_q[4];

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2 R3
  done_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(p_vld) && ($past(p_addr) == LAST_A)));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finished && !accepted) |=> ($stable(header_ok) && $stable(info_ok)
                                 && $stable(version_ok) && $stable(range_error)));

  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> (!header_ok && !info_ok && !version_ok && !range_error));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!done && !header_ok && !info_ok));

endmodule

// File: tb/tb_idrom_check.sv
`timescale 1ns/1ps
module tb_idrom_check;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [8:0]  rom_addr;
  logic [31:0] rom_data;
  logic        done, header_ok, info_ok, version_ok, range_error;
  logic [8:0]  off_info, off_proj, off_board, off_custom, off_second;

  logic [31:0] rom [512];
  int n_chk = 0;
  int n_bad = 0;
  bit finished_run = 0;

  always #2 clk = ~clk;

  always @(posedge clk) rom_data <= rom[rom_addr];

  idrom_check dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rom_addr(rom_addr), .rom_data(rom_data),
    .done(done), .header_ok(header_ok), .info_ok(info_ok), .version_ok(version_ok),
    .range_error(range_error), .off_info(off_info), .off_proj(off_proj),
    .off_board(off_board), .off_custom(off_custom), .off_second(off_second)
  );

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Checksum byte that cancels the bytes of rom[lo..hi], computed by shifting
  function automatic logic [7:0] cancel_byte(input int lo, input int hi);
    int total = 0;
    for (int a = lo; a <= hi; a++) begin
      logic [31:0] w = rom[a];
      for (int b = 0; b < 4; b++) begin
        total += int'(w & 32'hFF);
        w = w >> 8;
      end
    end
    return 8'((256 - (total % 256)) % 256);
  endfunction

  task automatic seal();
    rom[15] = {cancel_byte(0, 13), 24'h0};
    rom[33] = {cancel_byte(16, 31), 24'h0};
  endtask

  task automatic build_image();
    for (int a = 0; a < 512; a++) rom[a] = 32'hA5A5_0000 + a;
    rom[0] = 1; rom[1] = 16; rom[2] = 464; rom[3] = 472; rom[4] = 480; rom[5] = 0;
    for (int a = 6; a <= 14; a++) rom[a] = 0;
    for (int a = 16; a <= 31; a++) rom[a] = {8'(8'h61 + a), 8'(8'h30 + a), 8'(a * 3), 8'(a)};
    rom[32] = 0;
    seal();
  endtask

  // One scan: start at a negedge, follow rom_addr and done per cycle
  task automatic run_scan(input int poke_at, output int lat, output int pulses,
                          output int addr_bad, output bit ok_at_first);
    lat = 0; pulses = 0; addr_bad = 0; ok_at_first = 0;
    start = 1'b1;
    for (int cnt = 1; cnt <= 45; cnt++) begin
      @(negedge clk);
      start = (cnt == poke_at);
      if (cnt == 1) ok_at_first = header_ok | info_ok | version_ok;
      if (cnt <= 34 && rom_addr != 9'(cnt - 1)) addr_bad++;
      if (done) begin
        pulses++;
        if (lat == 0) lat = cnt;
      end
    end
    start = 1'b0;
  endtask

  task automatic scan_plain();
    int lat, pulses, abad; bit f;
    run_scan(0, lat, pulses, abad, f);
  endtask

  task automatic t_reset_boot();
    build_image();
    repeat (3) @(negedge clk);
    check(done == 0 && header_ok == 0 && info_ok == 0 && version_ok == 0 && range_error == 0,
          "R1 reset state", int'(done) + int'(header_ok), 0);
    rst_n = 1'b1;
    begin
      int seen = 0;
      for (int cnt = 1; cnt <= 45; cnt++) begin
        @(negedge clk);
        if (done && seen == 0) seen = cnt;
      end
      check(seen == 36, "R1 boot scan done cycle", seen, 36);
    end
    check(header_ok && info_ok && version_ok, "R1 boot scan results", int'(header_ok), 1);
  endtask

  task automatic t_good();
    int lat, pulses, abad; bit f;
    build_image();
    run_scan(0, lat, pulses, abad, f);
    check(abad == 0, "R2 address sequence", abad, 0);
    check(lat == 36, "R3 done cycle", lat, 36);
    check(pulses == 1, "R3 single done pulse", pulses, 1);
    check(f == 0, "R9 flags cleared at start", int'(f), 0);
    check(header_ok == 1, "R4 good header", int'(header_ok), 1);
    check(info_ok == 1, "R5 good info", int'(info_ok), 1);
    check(version_ok == 1, "R6 version 1", int'(version_ok), 1);
    check(range_error == 0, "R8 no range error", int'(range_error), 0);
    check(off_info == 16 && off_proj == 464 && off_board == 472 && off_custom == 480
          && off_second == 0, "R7 offsets", int'(off_proj), 464);
  endtask

  task automatic t_hdr_corrupt();
    build_image();
    rom[9] = rom[9] ^ 32'h0040_0000;
    scan_plain();
    check(header_ok == 0, "R4 header byte flip detected", int'(header_ok), 0);
    check(info_ok == 1, "R5 info unaffected by header flip", int'(info_ok), 1);
    build_image();
    rom[15] = rom[15] ^ 32'h0000_0100;
    scan_plain();
    check(header_ok == 0, "R4 nonzero low checksum bits", int'(header_ok), 0);
    build_image();
    rom[14] = 32'h0000_0001; rom[13] = 32'hFF;
    scan_plain();
    check(header_ok == 0, "R4 nonzero pad word", int'(header_ok), 0);
  endtask

  task automatic t_info_corrupt();
    build_image();
    rom[27] = rom[27] ^ 32'h0000_0008;
    scan_plain();
    check(info_ok == 0, "R5 info byte flip detected", int'(info_ok), 0);
    check(header_ok == 1, "R4 header unaffected by info flip", int'(header_ok), 1);
    build_image();
    rom[33] = rom[33] + 32'h0100_0000;
    scan_plain();
    check(info_ok == 0, "R5 wrong info checksum", int'(info_ok), 0);
    build_image();
    rom[32] = 32'h8000_0000;
    scan_plain();
    check(info_ok == 0, "R5 nonzero info pad", int'(info_ok), 0);
  endtask

  task automatic t_version();
    build_image();
    rom[0] = 2;
    seal();
    scan_plain();
    check(version_ok == 0, "R6 version 2 rejected", int'(version_ok), 0);
    check(header_ok == 1, "R4 header resealed", int'(header_ok), 1);
  endtask

  task automatic t_range();
    build_image();
    rom[2] = 600;
    seal();
    scan_plain();
    check(range_error == 1, "R8 pointer beyond ROM", int'(range_error), 1);
    check(off_proj == 9'd88, "R7 low bits of large pointer", int'(off_proj), 88);
    check(header_ok == 1, "R8 header still passes", int'(header_ok), 1);
    build_image();
    rom[5] = 511;
    seal();
    scan_plain();
    check(range_error == 0, "R8 last word in range", int'(range_error), 0);
    check(off_second == 9'd511, "R7 second pointer", int'(off_second), 511);
  endtask

  task automatic t_zero_sum();
    build_image();
    rom[13] = 0;
    rom[13] = {24'h0, cancel_byte(0, 12)};
    seal();
    check(rom[15] == 32'h0, "R10 bench image sums to zero", int'(rom[15] >> 24), 0);
    scan_plain();
    check(header_ok == 1, "R10 zero checksum accepted", int'(header_ok), 1);
  endtask

  task automatic t_restart_ignored();
    int lat, pulses, abad; bit f;
    build_image();
    run_scan(10, lat, pulses, abad, f);
    check(lat == 36, "R3 mid-scan start ignored (done cycle)", lat, 36);
    check(pulses == 1, "R3 mid-scan start ignored (pulses)", pulses, 1);
    check(abad == 0, "R3 mid-scan start ignored (addresses)", abad, 0);
  endtask

  task automatic t_hold();
    build_image();
    scan_plain();
    rom[3] = rom[3] ^ 32'hFF;
    rom[20] = rom[20] ^ 32'hFF00;
    repeat (20) @(negedge clk);
    check(header_ok && info_ok && off_board == 472, "R9 results held after ROM change",
          int'(header_ok) + int'(info_ok), 2);
  endtask

  initial begin
    t_reset_boot();
    t_good();
    t_hdr_corrupt();
    t_info_corrupt();
    t_version();
    t_range();
    t_zero_sum();
    t_restart_ignored();
    t_hold();
    finished_run = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished_run) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule